// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns an integer taken from a general-purpose register into a value ready to be written to a floating-point register. The source is 32 or 64 bits wide and is read as signed or unsigned. The result is rounded either to double precision or to single precision. In both cases it is delivered as a 64-bit IEEE binary64 pattern, so a single-precision result is a double whose low fraction bits are all zero. Combining the two widths, two signednesses and two precisions gives eight conversion variants.

The rounding direction comes from the caller. In the processor that caller is the current rounding field of the floating-point status register. When the record bit is set, the unit also classifies its own result into a 4-bit condition field. A build-time option lets a source register number of zero stand for the constant +0.0, whatever the operand contains. The unit is a fixed three-stage pipeline: extend and take the magnitude, normalise, then round and pack. It accepts a new operation on every cycle.

Top module: `i2f_convert`

## Requirements
- R1: After reset `done_o` is low. Each cycle with `start_i` high produces exactly one `done_o` pulse, three clock edges later. `done_o` is never high otherwise.
- R2: With `wide_i`=0 only `op_i[31:0]` is used. It is sign-extended when `signed_i`=1 and zero-extended when `signed_i`=0. `op_i[63:32]` has no effect.
- R3: With `wide_i`=1 the full 64 bits are read as two's complement when `signed_i`=1 and as unsigned when `signed_i`=0. A negative source gives result bit 63 = 1 and the magnitude in the other fields.
- R4: With `single_i`=0 the result is the IEEE binary64 encoding of the source rounded to a 53-bit significand: bit 63 sign, bits 62:52 biased exponent (bias 1023), bits 51:0 fraction.
- R5: With `single_i`=1 the source is rounded to a 24-bit significand and delivered in binary64 layout, so `result_o[28:0]` is zero.
- R6: `rmode_i` selects the rounding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R7: When rounding carries out of the significand, the exponent goes up by one and the fraction becomes zero (for example, unsigned all-ones rounds to exactly 2^64 under mode 0).
- R8: An integer zero gives +0.0 (all 64 bits zero) with `inexact_o`=0.
- R9: `inexact_o` is 1 exactly when some source bits below the kept significand are non-zero.
- R10: With `rc_i`=0, `cr1_o` is 0. With `rc_i`=1, `cr1_o` = {negative, positive, zero, inexact} for the delivered result.
- R11: When the parameter ZERO_REG_CLEARS is 1 and `ra_zero_i` is high with `start_i`, the result is +0.0 with `inexact_o`=0, whatever `op_i` holds.
- R12: Operations started on consecutive cycles each complete, in order, one per cycle, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a conversion on this cycle |
| op_i | input | 64 | Integer operand from the register file |
| ra_zero_i | input | 1 | Source register number is zero |
| signed_i | input | 1 | Read the source as two's complement |
| wide_i | input | 1 | 1 = 64-bit source, 0 = 32-bit source |
| single_i | input | 1 | 1 = round to single precision, 0 = double |
| rmode_i | input | 2 | Rounding direction (see R6) |
| rc_i | input | 1 | Record bit: produce the condition field |
| result_o | output | 64 | Result in binary64 layout |
| done_o | output | 1 | Result valid pulse |
| inexact_o | output | 1 | Discarded bits were non-zero |
| cr1_o | output | 4 | Condition field {neg, pos, zero, inexact} |

## Verification
Zero, one and powers of two are converted exactly, which isolates normalisation and exponent bias from rounding. Values one unit past 2^53 and 2^24, including their negatives, are run under all four rounding directions to separate ties-to-even from directed rounding and to show the effect of the sign. Unsigned all-ones and the most negative signed value exercise the significand carry and the magnitude edge. Operands with garbage in the upper word, zero-register requests, record bit on and off, back-to-back starts and a few hundred random operands compare every variant against a behavioural model that works by shifting right and comparing the remainder.

// File: rtl/i2f_convert.sv
module i2f_convert #(
  parameter bit ZERO_REG_CLEARS = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [63:0] op_i,
  input  logic        ra_zero_i,
  input  logic        signed_i,
  input  logic        wide_i,
  input  logic        single_i,
  input  logic [1:0]  rmode_i,
  input  logic        rc_i,
  output logic [63:0] result_o,
  output logic        done_o,
  output logic        inexact_o,
  output logic [3:0]  cr1_o
);

  localparam int DW      = 64;
  localparam int HW      = DW / 2;
  localparam int POS_W   = $clog2(DW);
  localparam int EXP_W   = 11;
  localparam int FRAC_D  = 52;
  localparam int FRAC_S  = 23;
  localparam int SIG_D   = FRAC_D + 1;
  localparam int SIG_S   = FRAC_S + 1;
  localparam int PAD_W   = FRAC_D - FRAC_S;
  localparam int LSB_D   = DW - SIG_D;
  localparam int LSB_S   = DW - SIG_S;
  localparam int BIAS    = 1023;

  // stage 1: extend, take magnitude
  logic [DW-1:0] ext_w, mag_w;
  logic          clr_w, neg_w;

  assign ext_w = wide_i ? op_i : {{HW{signed_i & op_i[HW-1]}}, op_i[HW-1:0]};
  assign clr_w = ZERO_REG_CLEARS && ra_zero_i;
  assign neg_w = signed_i & ext_w[DW-1] & ~clr_w;
  assign mag_w = clr_w ? '0 : (neg_w ? (~ext_w + 1'b1) : ext_w);

  logic          s1_v, s1_neg, s1_single, s1_rc;
  logic [1:0]    s1_rm;
  logic [DW-1:0] s1_mag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_neg <= 1'b0; s1_single <= 1'b0; s1_rc <= 1'b0;
      s1_rm <= '0; s1_mag <= '0;
    end else begin
      s1_v      <= start_i;
      s1_neg    <= neg_w;
      s1_single <= single_i;
      s1_rc     <= rc_i;
      s1_rm     <= rmode_i;
      s1_mag    <= mag_w;
    end
  end

  // stage 2: find leading one, normalise
  logic [POS_W-1:0] msb_w;
  logic [DW-1:0]    norm_w;

  always_comb begin
    msb_w = '0;
    for (int i = 0; i < DW; i++)
      if (s1_mag[i]) msb_w = POS_W'(i);
  end

  assign norm_w = s1_mag << (POS_W'(DW - 1) - msb_w);

  logic             s2_v, s2_neg, s2_single, s2_rc, s2_zero;
  logic [1:0]       s2_rm;
  logic [POS_W-1:0] s2_msb;
  logic [DW-1:0]    s2_norm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_neg <= 1'b0; s2_single <= 1'b0; s2_rc <= 1'b0;
      s2_zero <= 1'b1; s2_rm <= '0; s2_msb <= '0; s2_norm <= '0;
    end else begin
      s2_v      <= s1_v;
      s2_neg    <= s1_neg;
      s2_single <= s1_single;
      s2_rc     <= s1_rc;
      s2_zero   <= (s1_mag == '0);
      s2_rm     <= s1_rm;
      s2_msb    <= msb_w;
      s2_norm   <= norm_w;
    end
  end

  // stage 3: round and pack
  logic [SIG_D-1:0] kept_w, sum_w;
  logic             lsb_w, grd_w, stk_w, inc_w, carry_w, inx_w;
  logic [EXP_W-1:0] exp_w;
  logic [FRAC_D-1:0] frac_w;
  logic [DW-1:0]    res_w;
  logic [3:0]       cr_w;

  assign kept_w = s2_single ? {{(SIG_D-SIG_S){1'b0}}, s2_norm[DW-1:LSB_S]}
                            : s2_norm[DW-1:LSB_D];
  assign lsb_w  = s2_single ? s2_norm[LSB_S]     : s2_norm[LSB_D];
  assign grd_w  = s2_single ? s2_norm[LSB_S-1]   : s2_norm[LSB_D-1];
  assign stk_w  = s2_single ? |s2_norm[LSB_S-2:0] : |s2_norm[LSB_D-2:0];

  always_comb begin
    case (s2_rm)
      2'd0:    inc_w = grd_w & (stk_w | lsb_w);
      2'd1:    inc_w = 1'b0;
      2'd2:    inc_w = (grd_w | stk_w) & ~s2_neg;
      default: inc_w = (grd_w | stk_w) & s2_neg;
    endcase
  end

  assign sum_w   = kept_w + SIG_D'(inc_w);
  assign carry_w = s2_single ? sum_w[SIG_S] : ~sum_w[SIG_D-1];
  assign exp_w   = EXP_W'(BIAS) + EXP_W'(s2_msb) + EXP_W'(carry_w);
  assign frac_w  = s2_single ? {sum_w[FRAC_S-1:0], {PAD_W{1'b0}}} : sum_w[FRAC_D-1:0];
  assign inx_w   = ~s2_zero & (grd_w | stk_w);
  assign res_w   = s2_zero ? '0 : {s2_neg, exp_w, frac_w};
  assign cr_w    = s2_rc ? {~s2_zero & s2_neg, ~s2_zero & ~s2_neg, s2_zero, inx_w} : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0; result_o <= '0; inexact_o <= 1'b0; cr1_o <= '0;
    end else begin
      done_o <= s2_v;
      if (s2_v) begin
        result_o  <= res_w;
        inexact_o <= inx_w;
        cr1_o     <= cr_w;
      end
    end
  end

endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        single_i,
  input logic        rc_i,
  input logic        done_o,
  input logic [63:0] result_o,
  input logic        inexact_o,
  input logic [3:0]  cr1_o
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##3 done_o);

  assert_done_has_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && age == 2'd3) |-> $past(start_i, 3));

  assert_single_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && age == 2'd3 && $past(single_i, 3)) |-> (result_o[28:0] == 29'd0));

  assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o[62:0] == 63'd0) |-> (!result_o[63] && !inexact_o));

  assert_cr1_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && age == 2'd3 && !$past(rc_i, 3)) |-> (cr1_o == 4'd0));

  assert_cr1_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot0(cr1_o[3:1]));

endmodule

bind i2f_convert i2f_convert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .single_i(single_i), .rc_i(rc_i),
  .done_o(done_o), .result_o(result_o), .inexact_o(inexact_o), .cr1_o(cr1_o)
);

// File: tb/test_i2f_convert.sv
`timescale 1ns/1ps
module test_i2f_convert;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] op_i = '0;
  logic        ra_zero_i = 1'b0, signed_i = 1'b0, wide_i = 1'b0, single_i = 1'b0, rc_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic [63:0] result_o;
  logic        done_o, inexact_o;
  logic [3:0]  cr1_o;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R4";

  always #10 clk = ~clk;

  i2f_convert #(.ZERO_REG_CLEARS(1'b1)) i_i2f_convert (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .ra_zero_i(ra_zero_i),
    .signed_i(signed_i), .wide_i(wide_i), .single_i(single_i), .rmode_i(rmode_i),
    .rc_i(rc_i), .result_o(result_o), .done_o(done_o), .inexact_o(inexact_o), .cr1_o(cr1_o)
  );

  function automatic logic [68:0] model(input logic [63:0] op, input bit sgn, input bit wide,
                                        input bit sgl, input logic [1:0] rm, input bit rc, input bit raz);
    logic [63:0] v, mag, sig, rem, half, fr, res;
    bit neg, inx, up, gt, eq;
    int p, prec, k, e;
    logic [3:0] cr;
    v = wide ? op : (sgn ? {{32{op[31]}}, op[31:0]} : {32'd0, op[31:0]});
    neg = sgn && v[63];
    mag = neg ? (64'd0 - v) : v;
    if (raz) begin mag = 0; neg = 0; end
    prec = sgl ? 24 : 53;
    p = -1;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    if (p < 0) begin
      res = 0; inx = 0;
    end else begin
      k = p - (prec - 1);
      if (k <= 0) begin
        sig = mag << (-k); rem = 0; gt = 0; eq = 0;
      end else begin
        sig = mag >> k;
        rem = mag & ((64'd1 << k) - 1);
        half = 64'd1 << (k - 1);
        gt = rem > half; eq = rem == half;
      end
      inx = rem != 0;
      case (rm)
        2'd0: up = gt || (eq && sig[0]);
        2'd1: up = 0;
        2'd2: up = inx && !neg;
        default: up = inx && neg;
      endcase
      sig = sig + 64'(up);
      e = p;
      if (sig == (64'd1 << prec)) begin sig = sig >> 1; e = e + 1; end
      fr = (sig & ((64'd1 << (prec - 1)) - 1)) << (53 - prec);
      res = {neg, 11'(e + 1023), fr[51:0]};
    end
    cr = rc ? {p >= 0 && neg, p >= 0 && !neg, p < 0, inx} : 4'd0;
    return {res, inx, cr};
  endfunction

  bit          pv [3];
  logic [68:0] pexp [3];
  string       ptag [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin pv[i] = 0; pexp[i] = '0; ptag[i] = ""; end
    end else begin
      for (int i = 2; i > 0; i--) begin pv[i] = pv[i-1]; pexp[i] = pexp[i-1]; ptag[i] = ptag[i-1]; end
      pv[0] = start_i;
      pexp[0] = model(op_i, signed_i, wide_i, single_i, rmode_i, rc_i, ra_zero_i);
      ptag[0] = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done_o !== pv[2]) begin
        fails++;
        $display("FAIL R1 done: actual=%b expected=%b", done_o, pv[2]);
      end
      if (pv[2]) begin
        checks++;
        if ({result_o, inexact_o, cr1_o} !== pexp[2]) begin
          fails++;
          $display("FAIL %s result/inexact/cr1: actual=%h/%b/%b expected=%h/%b/%b", ptag[2],
                   result_o, inexact_o, cr1_o, pexp[2][68:5], pexp[2][4], pexp[2][3:0]);
        end
      end
    end
  end

  task automatic send(input logic [63:0] op, input bit sgn, input bit wide, input bit sgl,
                      input logic [1:0] rm, input bit rc, input bit raz, input string tag);
    @(negedge clk);
    op_i = op; signed_i = sgn; wide_i = wide; single_i = sgl; rmode_i = rm;
    rc_i = rc; ra_zero_i = raz; cur_tag = tag; start_i = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    start_i = 1'b0;
    op_i = 64'hFFFF_FFFF_FFFF_FFFF;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done_o !== 1'b0 || result_o !== 64'd0 || cr1_o !== 4'd0 || inexact_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual=%b/%h expected=0/0", done_o, result_o);
    end
    rst_n = 1'b1;

    send(64'd0, 1, 1, 0, 2'd0, 1, 0, "R8"); idle();
    send(64'd1, 0, 1, 0, 2'd0, 1, 0, "R4"); idle();
    send(64'd1 << 40, 0, 1, 1, 2'd0, 1, 0, "R5"); idle();
    send(64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 2'd0, 1, 0, "R3"); idle();
    send(64'h8000_0000_0000_0000, 1, 1, 0, 2'd0, 1, 0, "R3"); idle();
    send(64'h8000_0000_0000_0000, 0, 1, 0, 2'd0, 1, 0, "R3"); idle();
    send(64'hDEAD_BEEF_FFFF_FFFF, 1, 0, 0, 2'd0, 1, 0, "R2"); idle();
    send(64'hDEAD_BEEF_FFFF_FFFF, 0, 0, 0, 2'd0, 1, 0, "R2"); idle();
    send(64'h1234_5678_8000_0000, 1, 0, 1, 2'd0, 1, 0, "R2"); idle();
    send(64'h0000_0000_7FFF_FFFF, 0, 0, 1, 2'd0, 1, 0, "R5"); idle();
    for (int m = 0; m < 4; m++) begin
      send((64'd1 << 53) + 64'd1, 1, 1, 0, 2'(m), 1, 0, "R6"); idle();
      send((64'd1 << 53) + 64'd3, 1, 1, 0, 2'(m), 1, 0, "R6"); idle();
      send(64'd0 - ((64'd1 << 53) + 64'd1), 1, 1, 0, 2'(m), 1, 0, "R6"); idle();
      send(64'd0 - ((64'd1 << 24) + 64'd3), 1, 0, 1, 2'(m), 1, 0, "R6"); idle();
      send((64'd1 << 24) + 64'd1, 0, 1, 1, 2'(m), 1, 0, "R9"); idle();
      send(64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 2'(m), 1, 0, "R7"); idle();
      send(64'h0000_0000_FFFF_FFFF, 0, 0, 1, 2'(m), 1, 0, "R7"); idle();
    end
    send(64'd1 << 53, 0, 1, 0, 2'd0, 1, 0, "R9"); idle();
    send(64'd0 - 64'd77, 1, 1, 0, 2'd2, 0, 0, "R10"); idle();
    send(64'd0 - 64'd77, 1, 1, 1, 2'd3, 1, 0, "R10"); idle();
    send(64'd123, 1, 1, 0, 2'd0, 1, 1, "R11"); idle();
    send(64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 2'd3, 1, 1, "R11"); idle();
    send(64'd5, 0, 1, 0, 2'd0, 1, 0, "R12");
    send(64'd0 - 64'd9, 1, 1, 1, 2'd1, 1, 0, "R12");
    send(64'h0123_4567_89AB_CDEF, 0, 1, 0, 2'd2, 0, 0, "R12");
    send(64'd0, 0, 0, 1, 2'd0, 1, 0, "R12");
    idle();
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r;
      r = {$urandom, $urandom} >> ($urandom % 64);
      send(r, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
           ($urandom % 16) == 0, "R4");
      if ($urandom % 2) idle();
    end
    idle();
    repeat (6) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule